// File: doc/BRIEF.md
# System Bus Address Decoder with Default Responses

This block sits beside a shared system bus. It watches the address, transfer kind, transfer size and protection bits driven by the active master. From them it raises at most one slave-select line per transfer. A table of base/mask pairs, one pair per slave, defines the address map. When several regions match, the lowest slave index wins.

Whenever no slave is selected, the decoder itself drives the wait, error and last response lines. This covers idle and address-only cycles, decode turnaround cycles and rejected accesses. The bus therefore always sees a well-defined completion.

The decoder also acts as a simple protection unit. User-mode accesses to supervisor-only regions are rejected, and so are opcode fetches from regions marked non-executable. Accesses that use the reserved size code are rejected as well. Every rejected access completes with an error and no select.

Top module: `sysbus_addr_decoder`

## Requirements
- R1: At most one bit of `slv_sel` is high in any cycle. When an address matches several regions, the lowest-indexed slave is the one selected.
- R2: A transfer kind with bit 1 low is an address-only cycle: 2'b00, and the reserved code 2'b01, which is treated the same way. When such a kind is accepted, the next cycle has no select, with wait, error and last all low.
- R3: A non-sequential transfer (kind 2'b10) to a permitted, mapped address is followed by exactly one decode cycle (no select, wait high, error low, last low). After that cycle the matching slave is selected.
- R4: While a slave is selected, the response outputs follow the slave's wait, error and last inputs. While the slave's wait input is high, the select is held and the transfer inputs presented are ignored.
- R5: A sequential transfer (kind 2'b11) continues without a decode cycle in one case: it is accepted while a slave completes with last low and error low. The same slave is then selected in the next cycle, whatever the new address is.
- R6: A completion with last high or error high forces a fresh decode of the next transfer, including a sequential one, with its decode cycle. So does a sequential transfer accepted while no slave is selected.
- R7: An unmapped address is rejected: after the decode cycle comes one cycle with error high, wait low, last low and no select.
- R8: Protection bit 1 high marks a supervisor access and bit 0 high marks an opcode fetch. A user access (bit 1 low) to a supervisor-only region is rejected as in R7. So is a fetch (bit 0 high) from a no-fetch region.
- R9: Size codes are 2'b00 byte, 2'b01 half-word, 2'b10 word and 2'b11 reserved. The reserved size is rejected as in R7.
- R10: After a synchronous reset, no select is high and wait, error and last are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Transfer address from the active master |
| bus_kind | input | 2 | Transfer kind: 00 address-only, 01 reserved (address-only), 10 non-sequential, 11 sequential |
| bus_size | input | 2 | Transfer size: 00 byte, 01 half-word, 10 word, 11 reserved |
| bus_prot | input | 2 | Bit 1 supervisor, bit 0 opcode fetch |
| slv_wait_i | input | 1 | Wait response from the selected slave |
| slv_err_i | input | 1 | Error response from the selected slave |
| slv_last_i | input | 1 | Last response from the selected slave |
| slv_sel | output | NSLV | One select per slave |
| resp_wait | output | 1 | Wait response seen by the bus |
| resp_err | output | 1 | Error response seen by the bus |
| resp_last | output | 1 | Last response seen by the bus |

## Verification
A slave's completion and the master's next request can meet at the same clock edge. This is where burst continuation and forced re-decode compete. The bench provokes it three ways:
- a sequential request whose new address lies in another region, presented while the slave completes with last low; the old slave must stay selected;
- the same kind of request presented while the slave completes with last high;
- the same kind of request presented while the slave completes with error high.

In the last two cases, a decode cycle must be seen before the new select. Overlapping regions are also exercised together with the protection checks. A fetch hitting both a no-fetch region and a wider permissive one must be judged on the lower-indexed region alone.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  // transfer kind codes (bit 1 low means no data phase)
  localparam logic [1:0] XK_ADDR = 2'b00;
  localparam logic [1:0] XK_RSVD = 2'b01;
  localparam logic [1:0] XK_NSEQ = 2'b10;
  localparam logic [1:0] XK_SEQ  = 2'b11;

  // transfer size codes
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;

  // protection bit positions
  localparam int PROT_FETCH = 0;
  localparam int PROT_SUPER = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_FAULT  = 2'd3
  } dstate_e;

  typedef struct packed {
    logic stall;
    logic err;
    logic last;
  } resp_t;

  localparam resp_t RESP_QUIET  = '{stall: 1'b0, err: 1'b0, last: 1'b0};
  localparam resp_t RESP_DECODE = '{stall: 1'b1, err: 1'b0, last: 1'b0};
  localparam resp_t RESP_REJECT = '{stall: 1'b0, err: 1'b1, last: 1'b0};

endpackage

// File: rtl/sbd_region_match.sv
module sbd_region_match #(
  parameter int NSLV = 4,
  parameter int AW   = 32,
  parameter logic [NSLV*AW-1:0] BASE_MAP = '0,
  parameter logic [NSLV*AW-1:0] MASK_MAP = '0
) (
  input  logic [AW-1:0]   addr,
  output logic [NSLV-1:0] hit
);

  // one comparator per region: masked address equals base
  for (genvar g = 0; g < NSLV; g++) begin : g_region
    localparam logic [AW-1:0] RBASE = BASE_MAP[g*AW +: AW];
    localparam logic [AW-1:0] RMASK = MASK_MAP[g*AW +: AW];
    assign hit[g] = ((addr & RMASK) == RBASE);
  end

endmodule

// File: rtl/sbd_prio_pick.sv
module sbd_prio_pick #(
  parameter int NSLV = 4
) (
  input  logic [NSLV-1:0] req,
  output logic [NSLV-1:0] win,
  output logic            any
);

  // isolate the lowest set bit: lowest index wins on overlap
  assign win = req & (~req + NSLV'(1));
  assign any = |req;

endmodule

// File: rtl/sbd_access_check.sv
module sbd_access_check
  import sbd_pkg::*;
#(
  parameter int NSLV = 4,
  parameter logic [NSLV-1:0] SUPER_ONLY = '0,
  parameter logic [NSLV-1:0] NO_FETCH   = '0
) (
  input  logic [NSLV-1:0] win,
  input  logic            any,
  input  logic [1:0]      prot,
  input  logic [1:0]      size,
  output logic            fault
);

  logic unmapped, bad_size, priv_viol, exec_viol;

  always_comb begin
    unmapped  = !any;
    bad_size  = (size == SZ_RSVD);
    priv_viol = (|(win & SUPER_ONLY)) && !prot[PROT_SUPER];
    exec_viol = (|(win & NO_FETCH)) && prot[PROT_FETCH];
    fault     = unmapped || bad_size || priv_viol || exec_viol;
  end

endmodule

// File: rtl/sysbus_addr_decoder.sv
module sysbus_addr_decoder
  import sbd_pkg::*;
#(
  parameter int NSLV = 4,
  parameter int AW   = 32,
  parameter logic [NSLV*AW-1:0] BASE_MAP =
    {32'h2000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NSLV*AW-1:0] MASK_MAP =
    {32'hF000_0000, 32'hFF00_0000, 32'hF000_0000, 32'hF000_0000},
  parameter logic [NSLV-1:0] SUPER_ONLY = 4'b0010,
  parameter logic [NSLV-1:0] NO_FETCH   = 4'b0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic [1:0]      bus_kind,
  input  logic [1:0]      bus_size,
  input  logic [1:0]      bus_prot,
  input  logic            slv_wait_i,
  input  logic            slv_err_i,
  input  logic            slv_last_i,
  output logic [NSLV-1:0] slv_sel,
  output logic            resp_wait,
  output logic            resp_err,
  output logic            resp_last
);

  logic [NSLV-1:0] hit, win;
  logic            any, flt;

  sbd_region_match #(
    .NSLV(NSLV), .AW(AW), .BASE_MAP(BASE_MAP), .MASK_MAP(MASK_MAP)
  ) u_match (
    .addr(bus_addr),
    .hit (hit)
  );

  sbd_prio_pick #(.NSLV(NSLV)) u_pick (
    .req(hit),
    .win(win),
    .any(any)
  );

  sbd_access_check #(
    .NSLV(NSLV), .SUPER_ONLY(SUPER_ONLY), .NO_FETCH(NO_FETCH)
  ) u_chk (
    .win  (win),
    .any  (any),
    .prot (bus_prot),
    .size (bus_size),
    .fault(flt)
  );

  dstate_e         state_q, state_d;
  logic [NSLV-1:0] sel_q, sel_d;
  logic [NSLV-1:0] pend_q, pend_d;
  logic            pfault_q, pfault_d;
  resp_t           dflt_q, dflt_d;

  logic accept, addr_only, take_burst, in_active;

  assign in_active  = (state_q == ST_ACTIVE);
  assign accept     = !resp_wait;
  assign addr_only  = !bus_kind[1];
  assign take_burst = in_active && (bus_kind == XK_SEQ) && !slv_last_i && !slv_err_i;

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    pend_d   = pend_q;
    pfault_d = pfault_q;
    dflt_d   = dflt_q;
    if (accept) begin
      if (addr_only) begin
        state_d = ST_IDLE;
        sel_d   = '0;
        dflt_d  = RESP_QUIET;
      end else if (take_burst) begin
        state_d = ST_ACTIVE;
      end else begin
        state_d  = ST_DECODE;
        sel_d    = '0;
        pend_d   = win;
        pfault_d = flt;
        dflt_d   = RESP_DECODE;
      end
    end else if (state_q == ST_DECODE) begin
      if (pfault_q) begin
        state_d = ST_FAULT;
        sel_d   = '0;
        dflt_d  = RESP_REJECT;
      end else begin
        state_d = ST_ACTIVE;
        sel_d   = pend_q;
        dflt_d  = RESP_QUIET;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      pend_q   <= '0;
      pfault_q <= 1'b0;
      dflt_q   <= RESP_QUIET;
    end else begin
      state_q  <= state_d;
      sel_q    <= sel_d;
      pend_q   <= pend_d;
      pfault_q <= pfault_d;
      dflt_q   <= dflt_d;
    end
  end

  // selected slave owns the response lines, otherwise the decoder does
  assign slv_sel   = sel_q;
  assign resp_wait = in_active ? slv_wait_i : dflt_q.stall;
  assign resp_err  = in_active ? slv_err_i  : dflt_q.err;
  assign resp_last = in_active ? slv_last_i : dflt_q.last;

  // R1: never more than one select
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slv_sel));

  // R2: address-only cycle leaves the bus quiet
  p_addr_only_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!resp_wait && !bus_kind[1]) |=>
      (slv_sel == '0 && !resp_wait && !resp_err && !resp_last));

  // R3: non-sequential transfer gets a decode cycle
  p_decode_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (!resp_wait && bus_kind == XK_NSEQ) |=>
      (slv_sel == '0 && resp_wait && !resp_err && !resp_last));

  // R4: select held while the slave stretches the transfer
  p_hold_on_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (|slv_sel && slv_wait_i) |=> $stable(slv_sel));

  // R5: burst continues to the same slave
  p_burst_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (|slv_sel && !slv_wait_i && !slv_last_i && !slv_err_i && bus_kind == XK_SEQ)
      |=> (slv_sel == $past(slv_sel)));

  // R6: last response forces a select-free cycle before the next transfer
  p_last_redecode_r6: assert property (@(posedge clk) disable iff (rst)
    (|slv_sel && !slv_wait_i && slv_last_i) |=> (slv_sel == '0));

  // R7, R8, R9: rejected access completes with error after the decode cycle
  p_reject_resp_r7: assert property (@(posedge clk) disable iff (rst)
    (!resp_wait && bus_kind[1] && !take_burst && flt) |=> ##1
      (slv_sel == '0 && !resp_wait && resp_err && !resp_last));

endmodule

// File: tb/sim_sysbus_addr_decoder.sv
`timescale 1ns/1ps
module sim_sysbus_addr_decoder;

  localparam int NSLV = 4;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   bus_addr = '0;
  logic [1:0]      bus_kind = 2'b00;
  logic [1:0]      bus_size = 2'b10;
  logic [1:0]      bus_prot = 2'b10;
  logic            slv_wait_i = 1'b0;
  logic            slv_err_i  = 1'b0;
  logic            slv_last_i = 1'b0;
  logic [NSLV-1:0] slv_sel;
  logic            resp_wait, resp_err, resp_last;

  always #4 clk = ~clk;  // 125 MHz

  sysbus_addr_decoder u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_kind(bus_kind),
    .bus_size(bus_size), .bus_prot(bus_prot), .slv_wait_i(slv_wait_i),
    .slv_err_i(slv_err_i), .slv_last_i(slv_last_i), .slv_sel(slv_sel),
    .resp_wait(resp_wait), .resp_err(resp_err), .resp_last(resp_last)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  logic [6:0] expq[$];
  string      tagq[$];

  // codes
  localparam logic [1:0] AO = 2'b00, RV = 2'b01, NS = 2'b10, SQ = 2'b11;
  localparam logic [1:0] UD = 2'b00, SD = 2'b10, SF = 2'b11;

  // driver: drive one cycle of inputs and queue the outputs expected in it
  task automatic step(input logic [1:0] k, input logic [AW-1:0] a,
                      input logic [1:0] sz, input logic [1:0] pr,
                      input logic sw, input logic se, input logic sl,
                      input logic [3:0] es, input logic ew, input logic ee,
                      input logic el, input string tag);
    @(posedge clk);
    #1;
    bus_kind = k; bus_addr = a; bus_size = sz; bus_prot = pr;
    slv_wait_i = sw; slv_err_i = se; slv_last_i = sl;
    expq.push_back({es, ew, ee, el});
    tagq.push_back(tag);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [6:0] e;
      logic [6:0] got;
      string t;
      e   = expq.pop_front();
      t   = tagq.pop_front();
      got = {slv_sel, resp_wait, resp_err, resp_last};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: sel=%b w=%b e=%b l=%b expected sel=%b w=%b e=%b l=%b",
                 t, got[6:3], got[2], got[1], got[0], e[6:3], e[2], e[1], e[0]);
      end
    end
  end

  initial begin
    // R10: reset state
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 0,0,0, "R10");
    rst = 1'b0;
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 0,0,0, "R10");
    // R3: non-sequential to slave 0, decode cycle then select
    step(NS, 32'h0000_0100, 2'b10, SD, 0,0,0, 4'b0000, 0,0,0, "R2");
    step(NS, 32'h3000_0000, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R3");
    // R4: slave stretches
    step(AO, 32'h0, 2'b10, SD, 1,0,0, 4'b0001, 1,0,0, "R4");
    // R5: sequential with new address in another region, slave completes last low
    step(SQ, 32'h2000_0000, 2'b10, SD, 0,0,0, 4'b0001, 0,0,0, "R4");
    step(SQ, 32'h2000_0004, 2'b10, SD, 0,0,1, 4'b0001, 0,0,1, "R5");
    // R6: last high forces decode; R1 overlap picks slave 2
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R6");
    step(AO, 32'h0, 2'b10, SD, 0,1,0, 4'b0100, 0,1,0, "R1");
    // R2 then slave 3 user byte
    step(NS, 32'h2100_0000, 2'b00, UD, 0,0,0, 4'b0000, 0,0,0, "R2");
    step(SQ, 32'h2100_0000, 2'b00, UD, 0,0,0, 4'b0000, 1,0,0, "R3");
    // R6: error + last on completion, sequential must re-decode
    step(SQ, 32'h2100_0004, 2'b00, UD, 0,1,1, 4'b1000, 0,1,1, "R4");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R6");
    // R8: user access to supervisor-only slave 1
    step(NS, 32'h1000_0000, 2'b10, UD, 0,0,0, 4'b1000, 0,0,0, "R6");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R8");
    step(NS, 32'h1000_0000, 2'b01, SD, 0,0,0, 4'b0000, 0,1,0, "R8");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R8");
    // R8: supervisor fetch from no-fetch slave 2 (overlap winner)
    step(NS, 32'h2000_0000, 2'b10, SF, 0,0,0, 4'b0010, 0,0,0, "R8");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R8");
    // R1: fetch to slave 3 only is allowed
    step(NS, 32'h2100_0000, 2'b10, SF, 0,0,0, 4'b0000, 0,1,0, "R8");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R1");
    // R7: unmapped
    step(NS, 32'h3000_0000, 2'b10, SD, 0,0,0, 4'b1000, 0,0,0, "R1");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R7");
    // R9: reserved size
    step(NS, 32'h0000_0000, 2'b11, SD, 0,0,0, 4'b0000, 0,1,0, "R7");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R9");
    // R2: reserved kind behaves as address-only
    step(RV, 32'h0000_0000, 2'b10, SD, 0,0,0, 4'b0000, 0,1,0, "R9");
    // R6: sequential while nothing selected is decoded afresh
    step(SQ, 32'h0000_0000, 2'b10, SD, 0,0,0, 4'b0000, 0,0,0, "R2");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 1,0,0, "R6");
    // R4: transfer inputs ignored while the slave waits
    step(NS, 32'h3000_0000, 2'b10, SD, 1,0,0, 4'b0001, 1,0,0, "R4");
    step(AO, 32'h0, 2'b10, SD, 1,0,0, 4'b0001, 1,0,0, "R4");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0001, 0,0,0, "R4");
    step(AO, 32'h0, 2'b10, SD, 0,0,0, 4'b0000, 0,0,0, "R2");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule